// File: doc/BRIEF.md
# Reset Fetch Address Forcing Unit

This block produces the physical instruction-fetch address of a 32-bit processor from the moment reset is released. It holds a 16-bit code segment value and a 16-bit instruction offset. The address is formed the real-mode way: the segment is shifted left by four bits and the offset is added to it.

After reset, a single sticky flag forces the twelve upper address lines high. The first fetch therefore lands 16 bytes below the top of the 4 GB space, where a boot ROM can be placed. Sequential advances and near jumps change only the offset, so the flag stays set and execution remains in the top 64 KB.

The first far transfer loads a new segment and a new offset and drops the flag. From then on, fetches fall in the lowest megabyte, plus the carry into bit 20 that the segment arithmetic can produce. Only another reset sets the flag again.

Top module: `reset_fetch_addr`

## Requirements
- R1: While `rst` is high, on a clock edge the offset becomes FFF0h, the segment becomes F000h and the force flag is set, so the first fetch address after reset is FFFFFFF0h.
- R2: While the force flag is set, `fetch_addr[31:20]` are all one and `fetch_addr[19:0]` equal bits 19:0 of segment×16 + offset.
- R3: A `near_jmp` pulse with no `far_xfer` loads `near_ofs` into the offset at the clock edge, leaves the segment unchanged and leaves the force flag unchanged.
- R4: A `far_xfer` pulse loads `far_seg` and `far_ofs` at the clock edge and clears the force flag at that same edge.
- R5: While the force flag is clear, `fetch_addr` equals segment×16 + offset as a 21-bit sum, zero-extended. Bit 20 carries the sum's carry and bits 31:21 are zero.
- R6: When `fetch_req` and `adv` are both high, the offset advances by `adv_len` modulo 65536. When `adv` is high with `fetch_req` low, the offset is unchanged.
- R7: When strobes coincide, `far_xfer` takes precedence over `near_jmp`, and `near_jmp` takes precedence over an advance.
- R8: Once cleared, the force flag stays clear through any number of near jumps and advances until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | A fetch is being issued this cycle |
| adv | input | 1 | Sequential advance strobe |
| adv_len | input | 4 | Byte count for a sequential advance |
| near_jmp | input | 1 | Near jump strobe |
| near_ofs | input | 16 | Target offset for a near jump |
| far_xfer | input | 1 | Far jump or far call strobe |
| far_seg | input | 16 | Target segment for a far transfer |
| far_ofs | input | 16 | Target offset for a far transfer |
| fetch_addr | output | 32 | Physical fetch address |

## Verification
A force flag stuck set shows up in the first cycle after a far transfer: bits 31:20 stay at FFFh instead of dropping to zero. A flag that clears too early shows up on the first address after reset, which reads 000FFFF0h instead of FFFFFFF0h. An error in the offset or segment register, in carry handling or in strobe priority appears in the low address bits in the cycle after the strobe that caused it. The bench therefore compares the whole address against a reference model in every cycle.

// File: rtl/reset_fetch_addr.sv
module reset_fetch_addr #(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int OW = 16,
  parameter int FW = 12,
  parameter int LW = 4,
  parameter logic [SW-1:0] RST_SEG = 16'hF000,
  parameter logic [OW-1:0] RST_OFS = 16'hFFF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_req,
  input  logic          adv,
  input  logic [LW-1:0] adv_len,
  input  logic          near_jmp,
  input  logic [OW-1:0] near_ofs,
  input  logic          far_xfer,
  input  logic [SW-1:0] far_seg,
  input  logic [OW-1:0] far_ofs,
  output logic [AW-1:0] fetch_addr
);
  localparam int LINW = SW + 5;
  localparam int LOWW = AW - FW;

  logic [SW-1:0]   seg_q;
  logic [OW-1:0]   ofs_q;
  logic            force_q;
  logic [LINW-1:0] lin;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q   <= RST_SEG;
      ofs_q   <= RST_OFS;
      force_q <= 1'b1;
    end else if (far_xfer) begin
      seg_q   <= far_seg;
      ofs_q   <= far_ofs;
      force_q <= 1'b0;
    end else if (near_jmp) begin
      ofs_q <= near_ofs;
    end else if (adv && fetch_req) begin
      ofs_q <= ofs_q + OW'(adv_len);
    end
  end

  assign lin = {1'b0, seg_q, 4'h0} + LINW'(ofs_q);

  assign fetch_addr = force_q ? {{FW{1'b1}}, lin[LOWW-1:0]}
                              : {{(AW-LINW){1'b0}}, lin};
endmodule

module reset_fetch_addr_chk #(
  parameter int AW = 32,
  parameter int FW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          near_jmp,
  input logic          far_xfer,
  input logic          force_q,
  input logic [AW-1:0] fetch_addr
);
  a_r1_reset_addr: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> fetch_addr == 32'hFFFF_FFF0);
  a_r2_high_forced: assert property (@(posedge clk) disable iff (rst)
    force_q |-> &fetch_addr[AW-1:AW-FW]);
  a_r3_near_keeps_force: assert property (@(posedge clk) disable iff (rst)
    (near_jmp && !far_xfer) |=> $stable(force_q));
  a_r4_far_clears: assert property (@(posedge clk) disable iff (rst)
    far_xfer |=> !force_q);
  a_r5_low_window: assert property (@(posedge clk) disable iff (rst)
    !force_q |-> fetch_addr[AW-1:21] == '0);
  a_r8_sticky_clear: assert property (@(posedge clk) disable iff (rst)
    !force_q |=> !force_q);
endmodule

bind reset_fetch_addr reset_fetch_addr_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .near_jmp(near_jmp), .far_xfer(far_xfer),
  .force_q(force_q), .fetch_addr(fetch_addr)
);

// File: tb/reset_fetch_addr_bench.sv
module reset_fetch_addr_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        fetch_req = 0, adv = 0, near_jmp = 0, far_xfer = 0;
  logic [3:0]  adv_len = 0;
  logic [15:0] near_ofs = 0, far_seg = 0, far_ofs = 0;
  logic [31:0] fetch_addr;

  int errors = 0, checks = 0;
  logic [15:0] m_seg, m_ofs;
  logic        m_force;

  reset_fetch_addr u_reset_fetch_addr (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_addr(logic [15:0] s, logic [15:0] o, logic f);
    logic [20:0] l;
    l = {1'b0, s, 4'h0} + {5'h0, o};
    return f ? {12'hFFF, l[19:0]} : {11'h0, l};
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    checks++;
    if (fetch_addr !== exp) begin
      errors++;
      $display("FAIL %s: fetch_addr=%h expected=%h", tag, fetch_addr, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_seg = 16'hF000; m_ofs = 16'hFFF0; m_force = 1;
    end else if (far_xfer) begin
      m_seg = far_seg; m_ofs = far_ofs; m_force = 0;
    end else if (near_jmp) m_ofs = near_ofs;
    else if (adv && fetch_req) m_ofs = m_ofs + 16'(adv_len);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, exp_addr(m_seg, m_ofs, m_force));
    {rst, fetch_req, adv, near_jmp, far_xfer} = '0;
  endtask

  task automatic do_reset();
    rst = 1;
    step("R1");
    check("R1", 32'hFFFF_FFF0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R6: advance with wrap, and ignored without fetch_req
    fetch_req = 1; adv = 1; adv_len = 4'd9; step("R6");
    check("R6", 32'hFFFF_FFF9);
    adv = 1; adv_len = 4'd7; step("R6");
    check("R6", 32'hFFFF_FFF9);
    fetch_req = 1; adv = 1; adv_len = 4'd15; step("R6");
    check("R6", 32'hFFFF_0008);
    // R3: near jump keeps forcing
    near_jmp = 1; near_ofs = 16'h1234; fetch_req = 1; adv = 1; adv_len = 4'd3; step("R3");
    check("R3", 32'hFFFF_1234);
    // R7: far wins over near
    far_xfer = 1; far_seg = 16'h1000; far_ofs = 16'h0020;
    near_jmp = 1; near_ofs = 16'h5555; step("R7");
    check("R4", 32'h0001_0020);
    // R8: near jump after clear keeps it clear
    near_jmp = 1; near_ofs = 16'h0100; step("R8");
    check("R8", 32'h0001_0100);
    // R5: carry into bit 20
    far_xfer = 1; far_seg = 16'hFFFF; far_ofs = 16'hFFFF; step("R5");
    check("R5", 32'h0010_FFEF);
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      fetch_req = $urandom_range(0, 1);
      adv       = $urandom_range(0, 1);
      adv_len   = 4'($urandom);
      near_jmp  = (r < 15);
      near_ofs  = 16'($urandom);
      far_xfer  = (r >= 95);
      far_seg   = 16'($urandom);
      far_ofs   = 16'($urandom);
      rst       = ($urandom_range(0, 199) == 0);
      if (rst) step("R1");
      else if (far_xfer) step(near_jmp ? "R7" : "R4");
      else if (near_jmp) step("R3");
      else step(m_force ? "R2" : "R5");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule